// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block sits in front of an external memory bus controller that serves several chip selects. It decides when the next queued access may start. After the bus engine signals that an access has ended, the block holds its ready signal low for a computed number of bus clock cycles before it lets the next request launch.

The length of that idle gap is not a fixed turnaround. Three things decide it: whether the previous access was a read or a write, whether the next access goes to the same chip select, and the settings of the previous chip select. Each chip select has its own negation-cycle count, end-of-read delay count, and assert and negate offset fields. The block captures the settings of an access at the moment it launches. Later changes to the configuration therefore cannot change the gap that follows that access.

Requests arrive on a valid/ready port that carries a chip-select index and a write flag. An accepted request produces a one-cycle launch strobe toward the bus engine. The engine answers with a one-cycle done pulse when the access ends. Only one access is outstanding at a time. A debug output holds the delay that was computed for the most recent gap.

Top module: `idle_gap_gate`

## Requirements
- R1: After reset, reqReady is 1, launch is 0 and gapDelay is 0. The first request after reset is accepted with no delay, and the gapDelay it reports is 0.
- R2: From the cycle after a request is accepted until the cycle that carries accDone, reqReady stays 0, whatever reqValid does.
- R3: An accepted request (reqValid and reqReady both 1 at a rising edge) raises launch for exactly one cycle after that edge. In that cycle launchCs and launchWrite carry the accepted index and write flag (1 = write).
- R4: After a read, a read to the same chip select waits exactly the negation count (cfgNegCnt field) of the previous chip select. The end-of-read delay is not added.
- R5: After a read, a write to any chip select, or a read to a different chip select, waits the negation count plus the end-of-read delay (cfgRdTail field) of the previous chip select. The largest case is 15 + 15 = 30.
- R6: After a write, when both the assert and the negate offset fields of the previous chip select are zero, any following access waits the negation count. The end-of-read delay is never added after a write.
- R7: After a write, when the assert or the negate offset field of the previous chip select is nonzero, any following access waits 0 cycles.
- R8: The gap uses the configuration of the previous chip select as it stood when that access launched. The configuration of the next chip select, and changes made after launch, have no effect on the gap.
- R9: The wait counts from the accDone pulse. A delay of d means that reqReady first rises d cycles after the cycle following accDone; a delay of 0 allows acceptance in the cycle right after accDone. A request that arrives after the gap has elapsed is accepted at once. Each acceptance loads gapDelay with the delay that applied to it.

Per-chip-select fields are packed as cs*4 +: 4 in each cfg vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgNegCnt | input | 32 | Negation-cycle count per chip select, 4 bits each |
| cfgRdTail | input | 32 | End-of-read delay count per chip select, 4 bits each |
| cfgAssertOfs | input | 32 | Assert offset field per chip select, 4 bits each |
| cfgNegateOfs | input | 32 | Negate offset field per chip select, 4 bits each |
| reqValid | input | 1 | Request pending |
| reqCs | input | 3 | Target chip select of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqReady | output | 1 | Request may be accepted this cycle |
| accDone | input | 1 | One-cycle pulse: the access in flight has ended |
| launch | output | 1 | One-cycle strobe that starts the accepted access |
| launchCs | output | 3 | Chip select of the launched access |
| launchWrite | output | 1 | Write flag of the launched access |
| gapDelay | output | 5 | Delay computed for the most recent gap |

## Verification
The bench goes after the cases where the rule table branches:
- A same-chip-select read after a read. A design that adds the end-of-read delay here would wait 5 cycles instead of 3.
- A zero negation count with a nonzero end-of-read delay. This separates a 0-cycle gap from a 2-cycle gap.
- A write followed by a nonzero assert or negate offset. A design that ignores the offsets would wait the negation count instead of launching at once.
- Configuration that is rewritten while an access is in flight, and a next chip select whose own counts differ. These expose a design that reads live or next-target settings.
- A request that arrives after the gap has elapsed, and the 30-cycle maximum. These catch off-by-one counters and saturation bugs.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;
  typedef enum logic [1:0] {
    ST_FRESH,
    ST_BUSY,
    ST_GAP
  } gap_state_e;

  typedef struct packed {
    logic capture;  // request accepted this cycle
    logic fresh;    // no previous access since reset
    logic restart;  // previous access ended, clear elapsed counter
    logic advance;  // counting idle cycles
  } gap_strobe_t;
endpackage

// File: rtl/gap_ctrl.sv
module gap_ctrl
  import idle_gap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        accDone,
  input  logic        gapMet,
  output logic        reqReady,
  output gap_strobe_t strobe
);
  gap_state_e state, stateNext;
  logic take;

  assign reqReady = (state == ST_FRESH) || ((state == ST_GAP) && gapMet);
  assign take     = reqValid && reqReady;

  always_comb begin
    strobe.capture = take;
    strobe.fresh   = (state == ST_FRESH);
    strobe.restart = (state == ST_BUSY) && accDone;
    strobe.advance = (state == ST_GAP);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_FRESH: if (take) stateNext = ST_BUSY;
      ST_BUSY:  if (accDone) stateNext = ST_GAP;
      ST_GAP:   if (take) stateNext = ST_BUSY;
      default:  stateNext = ST_FRESH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FRESH;
    else       state <= stateNext;
  end
endmodule

// File: rtl/gap_datapath.sv
module gap_datapath
  import idle_gap_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CNT_W  = 4,
  parameter int OFS_W  = 4,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int SUM_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  gap_strobe_t             strobe,
  input  logic [NUM_CS*CNT_W-1:0] cfgNegCnt,
  input  logic [NUM_CS*CNT_W-1:0] cfgRdTail,
  input  logic [NUM_CS*OFS_W-1:0] cfgAssertOfs,
  input  logic [NUM_CS*OFS_W-1:0] cfgNegateOfs,
  input  logic [CS_W-1:0]         reqCs,
  input  logic                    reqWrite,
  output logic                    gapMet,
  output logic                    launch,
  output logic [CS_W-1:0]         launchCs,
  output logic                    launchWrite,
  output logic [SUM_W-1:0]        gapDelay
);
  logic [CNT_W-1:0] negArr  [NUM_CS];
  logic [CNT_W-1:0] tailArr [NUM_CS];
  logic             ofsNz   [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign negArr[i]  = cfgNegCnt[i*CNT_W +: CNT_W];
    assign tailArr[i] = cfgRdTail[i*CNT_W +: CNT_W];
    assign ofsNz[i]   = (cfgAssertOfs[i*OFS_W +: OFS_W] != '0) ||
                        (cfgNegateOfs[i*OFS_W +: OFS_W] != '0);
  end

  logic [CS_W-1:0]  prevCs;
  logic             prevWrite;
  logic [CNT_W-1:0] prevNeg;
  logic [CNT_W-1:0] prevTail;
  logic             prevOfsNz;
  logic [SUM_W-1:0] elapsed;
  logic [SUM_W-1:0] need;
  logic             sameRead;

  assign sameRead = !reqWrite && (reqCs == prevCs);

  always_comb begin
    if (prevWrite)
      need = prevOfsNz ? '0 : SUM_W'(prevNeg);
    else if (sameRead)
      need = SUM_W'(prevNeg);
    else
      need = SUM_W'(prevNeg) + SUM_W'(prevTail);
  end

  assign gapMet = (elapsed >= need);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCs    <= '0;
      prevWrite <= 1'b0;
      prevNeg   <= '0;
      prevTail  <= '0;
      prevOfsNz <= 1'b0;
    end else if (strobe.capture) begin
      prevCs    <= reqCs;
      prevWrite <= reqWrite;
      prevNeg   <= negArr[reqCs];
      prevTail  <= tailArr[reqCs];
      prevOfsNz <= ofsNz[reqCs];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      elapsed <= '0;
    else if (strobe.restart)
      elapsed <= '0;
    else if (strobe.advance && (elapsed != '1))
      elapsed <= elapsed + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      launch      <= 1'b0;
      launchCs    <= '0;
      launchWrite <= 1'b0;
      gapDelay    <= '0;
    end else begin
      launch <= strobe.capture;
      if (strobe.capture) begin
        launchCs    <= reqCs;
        launchWrite <= reqWrite;
        gapDelay    <= strobe.fresh ? '0 : need;
      end
    end
  end
endmodule

// File: rtl/idle_gap_gate.sv
module idle_gap_gate
  import idle_gap_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CNT_W  = 4,
  parameter int OFS_W  = 4,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int SUM_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CS*CNT_W-1:0] cfgNegCnt,
  input  logic [NUM_CS*CNT_W-1:0] cfgRdTail,
  input  logic [NUM_CS*OFS_W-1:0] cfgAssertOfs,
  input  logic [NUM_CS*OFS_W-1:0] cfgNegateOfs,
  input  logic                    reqValid,
  input  logic [CS_W-1:0]         reqCs,
  input  logic                    reqWrite,
  output logic                    reqReady,
  input  logic                    accDone,
  output logic                    launch,
  output logic [CS_W-1:0]         launchCs,
  output logic                    launchWrite,
  output logic [SUM_W-1:0]        gapDelay
);
  gap_strobe_t strobe;
  logic gapMet;

  gap_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .accDone(accDone),
    .gapMet(gapMet), .reqReady(reqReady), .strobe(strobe)
  );

  gap_datapath #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .OFS_W(OFS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgNegCnt(cfgNegCnt), .cfgRdTail(cfgRdTail),
    .cfgAssertOfs(cfgAssertOfs), .cfgNegateOfs(cfgNegateOfs),
    .reqCs(reqCs), .reqWrite(reqWrite), .gapMet(gapMet),
    .launch(launch), .launchCs(launchCs), .launchWrite(launchWrite),
    .gapDelay(gapDelay)
  );
endmodule

// File: rtl/idle_gap_chk.sv
module idle_gap_chk #(
  parameter int SUM_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             accDone,
  input logic             launch,
  input logic [SUM_W-1:0] gapDelay
);
  logic       take;
  logic       inFlight;
  logic       seenDone;
  logic [5:0] sinceDone;

  assign take = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight  <= 1'b0;
      seenDone  <= 1'b0;
      sinceDone <= '0;
    end else begin
      if (take) inFlight <= 1'b1;
      else if (accDone) inFlight <= 1'b0;
      if (accDone) begin
        seenDone  <= 1'b1;
        sinceDone <= '0;
      end else if (sinceDone != '1) begin
        sinceDone <= sinceDone + 1'b1;
      end
    end
  end

  // R2
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !reqReady);

  // R3
  launch_follows_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    take |=> launch);

  // R3
  launch_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> !launch);

  // R9
  gap_respected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (take && seenDone) |=> (6'(gapDelay) <= $past(sinceDone)));

  // R1
  first_gap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (take && !seenDone) |=> (gapDelay == '0));
endmodule

bind idle_gap_gate idle_gap_chk #(.SUM_W(SUM_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .accDone(accDone), .launch(launch), .gapDelay(gapDelay)
);

// File: tb/idle_gap_gate_tb.sv
module idle_gap_gate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgNegCnt = '0, cfgRdTail = '0, cfgAssertOfs = '0, cfgNegateOfs = '0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqCs = '0;
  logic        reqWrite = 1'b0;
  logic        reqReady;
  logic        accDone = 1'b0;
  logic        launch;
  logic [2:0]  launchCs;
  logic        launchWrite;
  logic [4:0]  gapDelay;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  idle_gap_gate dut_i (
    .clk(clk), .rstN(rstN), .cfgNegCnt(cfgNegCnt), .cfgRdTail(cfgRdTail),
    .cfgAssertOfs(cfgAssertOfs), .cfgNegateOfs(cfgNegateOfs),
    .reqValid(reqValid), .reqCs(reqCs), .reqWrite(reqWrite), .reqReady(reqReady),
    .accDone(accDone), .launch(launch), .launchCs(launchCs),
    .launchWrite(launchWrite), .gapDelay(gapDelay)
  );

  typedef struct packed {
    logic [3:0] neg;
    logic [3:0] tail;
    logic [3:0] aOfs;
    logic [3:0] nOfs;
    logic       prevWr;
    logic [2:0] nextCs;
    logic       nextWr;
    logic [4:0] expGap;
  } vec_t;

  // previous access always goes to chip select 4
  localparam vec_t VECS [14] = '{
    '{4'd3, 4'd0, 4'd0, 4'd0, 1'b0, 3'd4, 1'b0, 5'd3},   // R4
    '{4'd3, 4'd0, 4'd0, 4'd0, 1'b0, 3'd2, 1'b0, 5'd3},   // R5
    '{4'd3, 4'd0, 4'd0, 4'd0, 1'b0, 3'd4, 1'b1, 5'd3},   // R5
    '{4'd3, 4'd2, 4'd0, 4'd0, 1'b0, 3'd4, 1'b0, 5'd3},   // R4
    '{4'd3, 4'd2, 4'd0, 4'd0, 1'b0, 3'd2, 1'b0, 5'd5},   // R5
    '{4'd3, 4'd2, 4'd0, 4'd0, 1'b0, 3'd4, 1'b1, 5'd5},   // R5
    '{4'd3, 4'd2, 4'd0, 4'd0, 1'b0, 3'd2, 1'b1, 5'd5},   // R5
    '{4'd0, 4'd2, 4'd0, 4'd0, 1'b0, 3'd4, 1'b0, 5'd0},   // R4
    '{4'd0, 4'd2, 4'd0, 4'd0, 1'b0, 3'd2, 1'b1, 5'd2},   // R5
    '{4'd3, 4'd2, 4'd0, 4'd0, 1'b1, 3'd4, 1'b0, 5'd3},   // R6
    '{4'd3, 4'd2, 4'd0, 4'd0, 1'b1, 3'd2, 1'b1, 5'd3},   // R6
    '{4'd3, 4'd2, 4'd1, 4'd0, 1'b1, 3'd2, 1'b0, 5'd0},   // R7
    '{4'd3, 4'd2, 4'd0, 4'd1, 1'b1, 3'd4, 1'b1, 5'd0},   // R7
    '{4'd15, 4'd15, 4'd0, 4'd0, 1'b0, 3'd2, 1'b0, 5'd30} // R5
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setCfg(input int cs, input logic [3:0] neg, input logic [3:0] tail,
                        input logic [3:0] a, input logic [3:0] n);
    cfgNegCnt[cs*4 +: 4]    = neg;
    cfgRdTail[cs*4 +: 4]    = tail;
    cfgAssertOfs[cs*4 +: 4] = a;
    cfgNegateOfs[cs*4 +: 4] = n;
  endtask

  // present a request and hold it until accepted; returns at the negedge after acceptance
  task automatic issue(input logic [2:0] cs, input logic wr);
    reqValid = 1'b1; reqCs = cs; reqWrite = wr;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic pulseDone();
    accDone = 1'b1;
    @(negedge clk);
    accDone = 1'b0;
  endtask

  // next request is already waiting when done arrives; returns the measured gap
  task automatic gapRun(input logic [2:0] cs, input logic wr, output int gap);
    reqValid = 1'b1; reqCs = cs; reqWrite = wr;
    pulseDone();
    gap = 0;
    while (!reqReady && gap < 64) begin
      @(negedge clk);
      gap++;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishAccess();
    pulseDone();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int gap;
    setCfg(2, 4'd7, 4'd7, 4'd0, 4'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    check(launch == 1'b0, "R1 launch after reset", launch, 0);
    check(gapDelay == 5'd0, "R1 gapDelay after reset", gapDelay, 0);

    // R1 first request goes at once; R3 launch fields
    setCfg(4, 4'd3, 4'd2, 4'd0, 4'd0);
    reqValid = 1'b1; reqCs = 3'd4; reqWrite = 1'b1;
    check(reqReady == 1'b1, "R1 first request ready", reqReady, 1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(launch == 1'b1, "R3 launch strobe", launch, 1);
    check(launchCs == 3'd4, "R3 launchCs", launchCs, 4);
    check(launchWrite == 1'b1, "R3 launchWrite", launchWrite, 1);
    check(gapDelay == 5'd0, "R1 first gapDelay", gapDelay, 0);
    @(negedge clk);
    check(launch == 1'b0, "R3 launch one cycle", launch, 0);

    // R2 blocked while in flight
    reqValid = 1'b1; reqCs = 3'd1; reqWrite = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check(reqReady == 1'b0, "R2 ready low in flight", reqReady, 0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    finishAccess();

    // table walk
    foreach (VECS[i]) begin
      setCfg(4, VECS[i].neg, VECS[i].tail, VECS[i].aOfs, VECS[i].nOfs);
      issue(3'd4, VECS[i].prevWr);
      repeat (2) @(negedge clk);
      gapRun(VECS[i].nextCs, VECS[i].nextWr, gap);
      check(gap == int'(VECS[i].expGap), $sformatf("R4-R7 table row %0d gap", i),
            gap, VECS[i].expGap);
      check(gapDelay == VECS[i].expGap, $sformatf("R9 table row %0d gapDelay", i),
            gapDelay, VECS[i].expGap);
      check(launch == 1'b1 && launchCs == VECS[i].nextCs,
            $sformatf("R3 table row %0d launch cs", i), launchCs, VECS[i].nextCs);
      finishAccess();
    end

    // R8 config rewritten after launch is ignored
    setCfg(4, 4'd3, 4'd0, 4'd0, 4'd0);
    issue(3'd4, 1'b0);
    setCfg(4, 4'd9, 4'd9, 4'd0, 4'd0);
    repeat (2) @(negedge clk);
    gapRun(3'd4, 1'b0, gap);
    check(gap == 3, "R8 captured config gap", gap, 3);
    finishAccess();

    // R8 next chip select config does not matter: prev cs2 (7,7) read -> cs4 read
    issue(3'd2, 1'b0);
    repeat (2) @(negedge clk);
    gapRun(3'd4, 1'b0, gap);
    check(gap == 14, "R8 prev cs config used", gap, 14);
    check(gapDelay == 5'd14, "R9 gapDelay prev cs", gapDelay, 14);
    finishAccess();

    // R9 late request accepted at once after gap elapsed
    setCfg(4, 4'd3, 4'd2, 4'd0, 4'd0);
    issue(3'd4, 1'b0);
    pulseDone();
    repeat (10) @(negedge clk);
    reqValid = 1'b1; reqCs = 3'd2; reqWrite = 1'b0;
    check(reqReady == 1'b1, "R9 late request ready", reqReady, 1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(launch == 1'b1, "R9 late launch", launch, 1);
    check(gapDelay == 5'd5, "R9 late gapDelay", gapDelay, 5);
    finishAccess();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule